// File: doc/BRIEF.md
# Two-Wire Slave Address Decoder and Target Router

This block is the front end of a two-wire serial slave. It oversamples the clock and data lines with the system clock and detects START and STOP conditions. After each START it shifts in the first byte. When that byte addresses this device, the block acknowledges it on the ninth clock and selects one of three internal targets: a memory array, a control/status register, or the potentiometer wiper registers. The low bit of the byte sets the direction of the transfer.

In a write, each further byte is acknowledged and passed to the selected target as a one-cycle strobe carrying the byte and its position in the transaction. An input that reflects the write-enable latch gates writes to the memory array and to the potentiometers. In a read, the block fetches a byte from its read-data input, shifts it out MSB first and keeps going for as long as the master acknowledges. The storage behind the strobes and the read-data port lies outside the block.

Top module: `i2cTargetRouter`

## Requirements
- R1: The address byte is acknowledged only when bits 7..4 equal 1010 and bit 3 equals `strapA0`. Otherwise the block does not pull SDA low at any point until the next START.
- R2: Address bits 2..1 select the target and set `tgtSel` one-hot: code 00 gives bit 0 (memory), 10 gives bit 1 (control/status) and 11 gives bit 2 (potentiometers). Code 01 is reserved: it is not acknowledged and leaves `tgtSel` at zero.
- R3: Address bit 0 sets `isRead` (1 is read, 0 is write) for the rest of the transaction. No write strobe is produced during a read.
- R4: In a write, each data byte is acknowledged and produces exactly one single-cycle pulse on the `wrStrobe` bit of the selected target. The pulse comes with the byte on `wrData` and the zero-based data-byte index on `dataIdx`.
- R5: When `weLatch` is low, writes to the memory or potentiometer targets are still acknowledged but produce no strobe. Writes to the control/status target do not depend on `weLatch`.
- R6: A write accepts at most MaxWr data bytes (2 by default). Any further byte is not acknowledged and produces no strobe.
- R7: In a read, `rdData` is captured at the end of the acknowledge clock and `rdStrobe` pulses once for each captured byte. The byte is driven MSB first, with SDA pulled low for 0 bits, and SDA is released during the ninth clock.
- R8: If the master acknowledges a read byte, the next byte is captured and sent. If the master does not acknowledge, the block releases SDA and stays silent until the next START.
- R9: A STOP clears `tgtSel`, `isRead` and `sdaDriveLow`.
- R10: A repeated START in the middle of a transaction restarts address reception without a STOP.
- R11: After reset all outputs are zero.
- R12: `sdaDriveLow` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| strapA0 | input | 1 | Pin-strapped device address bit |
| weLatch | input | 1 | Write-enable latch state |
| rdData | input | 8 | Byte that the selected target offers for reading |
| sdaDriveLow | output | 1 | Pull SDA low when high (open drain) |
| tgtSel | output | 3 | One-hot selected target: memory, control/status, potentiometers |
| isRead | output | 1 | Current transaction is a read |
| wrStrobe | output | 3 | One-cycle write pulse per target |
| wrData | output | 8 | Byte written with `wrStrobe` |
| dataIdx | output | 2 | Data-byte index in the transaction |
| rdStrobe | output | 1 | Pulse when a read byte is captured |

## Verification
The hardest states to reach are the boundaries between frames. Examples are a master NACK that must silence the block for the rest of a read, a third write byte beyond the limit, and a repeated START that arrives just after a write acknowledge while the block is still releasing SDA. The bench drives the bus bit by bit from tasks, so it can chain these sequences directly. A monitor that runs on every clock flags any pull-down of SDA while SCL is high outside a window in which the reference model expects one. Write strobes are collected into a queue and compared with the queue the model predicts.

// File: rtl/i2cRouterPkg.sv
`timescale 1ns/1ps
package i2cRouterPkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;
  localparam int IDX_W  = 2;
  localparam int NUM_TGT = 3;

  localparam logic [1:0] TGT_MEM  = 2'b00;
  localparam logic [1:0] TGT_RSV  = 2'b01;
  localparam logic [1:0] TGT_STAT = 2'b10;
  localparam logic [1:0] TGT_POT  = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDATA, ST_WACK, ST_RDATA, ST_WAIT
  } state_t;

  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic start;
    logic stop;
    logic sdaBit;
  } busEv_t;

  typedef struct packed {
    logic latchAddr;
    logic clrAddr;
    logic loadTx;
    logic shiftTx;
  } dpCmd_t;

  function automatic logic [NUM_TGT-1:0] tgtOneHot(input logic [1:0] code);
    logic [NUM_TGT-1:0] oh;
    case (code)
      TGT_MEM:  oh = 3'b001;
      TGT_STAT: oh = 3'b010;
      TGT_POT:  oh = 3'b100;
      default:  oh = 3'b000;
    endcase
    return oh;
  endfunction
endpackage

// File: rtl/i2cRouterDp.sv
`timescale 1ns/1ps
module i2cRouterDp
  import i2cRouterPkg::*;
#(
  parameter int SyncStages = 2,
  parameter logic [3:0] DevType = 4'b1010
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic strapA0,
  input  logic [BYTE_W-2:0] rdLow,
  input  dpCmd_t cmd,
  output busEv_t ev,
  output logic sclLevel,
  output logic addrOk,
  output logic txNext,
  output logic [BYTE_W-1:0] rxByte,
  output logic [NUM_TGT-1:0] tgtSel,
  output logic isRead
);
  logic [SyncStages-1:0] sclSh, sdaSh;
  logic sclPrev, sdaPrev;
  logic sclS, sdaS;
  logic [BYTE_W-2:0] txSh;

  generate
    if (SyncStages == 1) begin : gSync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin sclSh <= '1; sdaSh <= '1; end
        else begin sclSh <= sclIn; sdaSh <= sdaIn; end
    end else begin : gSyncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin sclSh <= '1; sdaSh <= '1; end
        else begin
          sclSh <= {sclSh[SyncStages-2:0], sclIn};
          sdaSh <= {sdaSh[SyncStages-2:0], sdaIn};
        end
    end
  endgenerate

  assign sclS = sclSh[SyncStages-1];
  assign sdaS = sdaSh[SyncStages-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin sclPrev <= 1'b1; sdaPrev <= 1'b1; end
    else begin sclPrev <= sclS; sdaPrev <= sdaS; end

  assign ev.sclRise = sclS & ~sclPrev;
  assign ev.sclFall = ~sclS & sclPrev;
  assign ev.start   = sclS & sclPrev & sdaPrev & ~sdaS;
  assign ev.stop    = sclS & sclPrev & ~sdaPrev & sdaS;
  assign ev.sdaBit  = sdaS;
  assign sclLevel   = sclS;

  // receive shifter: every rising SCL edge shifts one bit in
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) rxByte <= '0;
    else if (ev.sclRise) rxByte <= {rxByte[BYTE_W-2:0], sdaS};

  assign addrOk = (rxByte[7:4] == DevType) && (rxByte[3] == strapA0)
                  && (rxByte[2:1] != TGT_RSV);

  // transmit shifter keeps the bits below the one already on the bus
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) txSh <= '0;
    else if (cmd.loadTx) txSh <= rdLow;
    else if (cmd.shiftTx) txSh <= {txSh[BYTE_W-3:0], 1'b0};

  assign txNext = txSh[BYTE_W-2];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin tgtSel <= '0; isRead <= 1'b0; end
    else if (cmd.clrAddr) begin tgtSel <= '0; isRead <= 1'b0; end
    else if (cmd.latchAddr) begin
      tgtSel <= tgtOneHot(rxByte[2:1]);
      isRead <= rxByte[0];
    end
endmodule

// File: rtl/i2cRouterCtl.sv
`timescale 1ns/1ps
module i2cRouterCtl
  import i2cRouterPkg::*;
#(
  parameter int MaxWr = 2
) (
  input  logic clk,
  input  logic rstN,
  input  busEv_t ev,
  input  logic addrOk,
  input  logic txNext,
  input  logic rdMsb,
  input  logic weLatch,
  input  logic [NUM_TGT-1:0] tgtSel,
  input  logic isRead,
  output dpCmd_t cmd,
  output logic sdaLow,
  output logic [NUM_TGT-1:0] wrStrobe,
  output logic rdStrobe,
  output logic [IDX_W-1:0] dataIdx
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

  state_t state;
  logic [CNT_W-1:0] bitCnt;
  logic mAck;
  logic frameOn, fallLast, fallAck, wrRoom, wrAllowed;

  assign frameOn  = (state != ST_IDLE) && (state != ST_WAIT);
  assign fallLast = ev.sclFall && (bitCnt == LAST_BIT);
  assign fallAck  = ev.sclFall && (bitCnt == ACK_BIT);
  assign wrRoom   = int'(dataIdx) < MaxWr;
  assign wrAllowed = weLatch || tgtSel[1];

  always_comb begin
    cmd.clrAddr   = ev.start || ev.stop;
    cmd.latchAddr = (state == ST_ADDR) && fallLast && addrOk;
    cmd.loadTx    = fallAck && (((state == ST_AACK) && isRead) ||
                                ((state == ST_RDATA) && mAck));
    cmd.shiftTx   = ev.sclFall && (state == ST_RDATA) &&
                    (bitCnt != '0) && (bitCnt < LAST_BIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      dataIdx  <= '0;
      sdaLow   <= 1'b0;
      mAck     <= 1'b0;
      wrStrobe <= '0;
      rdStrobe <= 1'b0;
    end else begin
      wrStrobe <= '0;
      rdStrobe <= cmd.loadTx;
      if (ev.start) begin
        state <= ST_ADDR; bitCnt <= '0; dataIdx <= '0; sdaLow <= 1'b0;
      end else if (ev.stop) begin
        state <= ST_IDLE; bitCnt <= '0; sdaLow <= 1'b0;
      end else if (ev.sclRise && frameOn) begin
        bitCnt <= bitCnt + 1'b1;
        if ((state == ST_RDATA) && (bitCnt == LAST_BIT)) mAck <= ~ev.sdaBit;
      end else if (ev.sclFall) begin
        case (state)
          ST_ADDR:
            if (fallLast) begin
              if (addrOk) begin state <= ST_AACK; sdaLow <= 1'b1; end
              else state <= ST_WAIT;
            end
          ST_AACK:
            if (fallAck) begin
              bitCnt <= '0;
              if (isRead) begin state <= ST_RDATA; sdaLow <= ~rdMsb; end
              else begin state <= ST_WDATA; sdaLow <= 1'b0; end
            end
          ST_WDATA:
            if (fallLast) begin
              if (wrRoom) begin
                state <= ST_WACK;
                sdaLow <= 1'b1;
                wrStrobe <= wrAllowed ? tgtSel : '0;
              end else state <= ST_WAIT;
            end
          ST_WACK:
            if (fallAck) begin
              state <= ST_WDATA; sdaLow <= 1'b0; bitCnt <= '0;
              if (dataIdx != '1) dataIdx <= dataIdx + 1'b1;
            end
          ST_RDATA:
            if (cmd.shiftTx) sdaLow <= ~txNext;
            else if (fallLast) sdaLow <= 1'b0;
            else if (fallAck) begin
              bitCnt <= '0;
              if (mAck) begin
                sdaLow <= ~rdMsb;
                if (dataIdx != '1) dataIdx <= dataIdx + 1'b1;
              end else begin
                state <= ST_WAIT; sdaLow <= 1'b0;
              end
            end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cTargetRouter.sv
`timescale 1ns/1ps
module i2cTargetRouter
  import i2cRouterPkg::*;
#(
  parameter int SyncStages = 2,
  parameter logic [3:0] DevType = 4'b1010,
  parameter int MaxWr = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic strapA0,
  input  logic weLatch,
  input  logic [7:0] rdData,
  output logic sdaDriveLow,
  output logic [2:0] tgtSel,
  output logic isRead,
  output logic [2:0] wrStrobe,
  output logic [7:0] wrData,
  output logic [1:0] dataIdx,
  output logic rdStrobe
);
  busEv_t ev;
  dpCmd_t cmd;
  logic sclLevel, addrOk, txNext;
  logic stopPulse, startPulse;
  logic [BYTE_W-1:0] rxByte;

  i2cRouterDp #(.SyncStages(SyncStages), .DevType(DevType)) uDp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strapA0(strapA0),
    .rdLow(rdData[BYTE_W-2:0]), .cmd(cmd), .ev(ev), .sclLevel(sclLevel),
    .addrOk(addrOk), .txNext(txNext), .rxByte(rxByte),
    .tgtSel(tgtSel), .isRead(isRead)
  );

  i2cRouterCtl #(.MaxWr(MaxWr)) uCtl (
    .clk(clk), .rstN(rstN), .ev(ev), .addrOk(addrOk), .txNext(txNext),
    .rdMsb(rdData[BYTE_W-1]), .weLatch(weLatch), .tgtSel(tgtSel),
    .isRead(isRead), .cmd(cmd), .sdaLow(sdaDriveLow), .wrStrobe(wrStrobe),
    .rdStrobe(rdStrobe), .dataIdx(dataIdx)
  );

  assign wrData     = rxByte;
  assign stopPulse  = ev.stop;
  assign startPulse = ev.start;
endmodule

// File: rtl/i2cTargetRouterChk.sv
`timescale 1ns/1ps
module i2cTargetRouterChk #(
  parameter int MaxWr = 2
) (
  input logic clk,
  input logic rstN,
  input logic sclLevel,
  input logic stopPulse,
  input logic startPulse,
  input logic weLatch,
  input logic sdaDriveLow,
  input logic [2:0] tgtSel,
  input logic isRead,
  input logic [2:0] wrStrobe,
  input logic [1:0] dataIdx,
  input logic rdStrobe
);
  a_r12_drive_changes_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaDriveLow) && !$past(stopPulse || startPulse)) |-> !sclLevel);

  a_r2_sel_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tgtSel));

  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrStrobe));

  a_r4_strobe_to_selected: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe != 3'b000) |-> ((wrStrobe & tgtSel) == wrStrobe));

  a_r5_locked_targets: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe[0] || wrStrobe[2]) |-> $past(weLatch));

  a_r3_no_write_in_read: assert property (@(posedge clk) disable iff (!rstN)
    isRead |-> (wrStrobe == 3'b000));

  a_r6_write_limit: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe != 3'b000) |-> (int'(dataIdx) < MaxWr));

  a_r7_fetch_only_read: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |-> isRead);

  a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    stopPulse |=> (tgtSel == 3'b000 && !isRead && !sdaDriveLow));
endmodule

bind i2cTargetRouter i2cTargetRouterChk #(.MaxWr(MaxWr)) uChk (
  .clk(clk), .rstN(rstN), .sclLevel(sclLevel), .stopPulse(stopPulse),
  .startPulse(startPulse), .weLatch(weLatch), .sdaDriveLow(sdaDriveLow),
  .tgtSel(tgtSel), .isRead(isRead), .wrStrobe(wrStrobe), .dataIdx(dataIdx),
  .rdStrobe(rdStrobe)
);

// File: tb/sim_i2cTargetRouter.sv
`timescale 1ns/1ps
module sim_i2cTargetRouter;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic strapA0 = 1'b1, weLatch = 1'b1;
  logic [7:0] rdData = 8'h00;
  logic sdaDriveLow, isRead, rdStrobe;
  logic [2:0] tgtSel, wrStrobe;
  logic [7:0] wrData;
  logic [1:0] dataIdx;
  wire sdaBus = sdaM & ~sdaDriveLow;

  int checks = 0, errors = 0, rdCount = 0;
  bit mayDrive = 1'b0;
  bit done = 1'b0;
  logic [12:0] expQ[$];
  logic [12:0] gotQ[$];

  i2cTargetRouter u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .strapA0(strapA0),
    .weLatch(weLatch), .rdData(rdData), .sdaDriveLow(sdaDriveLow),
    .tgtSel(tgtSel), .isRead(isRead), .wrStrobe(wrStrobe), .wrData(wrData),
    .dataIdx(dataIdx), .rdStrobe(rdStrobe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // target model: collects strobes, advances the read byte on every fetch
  always @(posedge clk) if (rstN) begin
    if (wrStrobe != 3'b000) gotQ.push_back({wrStrobe, wrData, dataIdx});
    if (rdStrobe) rdCount++;
  end
  always @(negedge clk) if (rstN && rdStrobe) rdData <= rdData + 8'h11;

  // every clock: no pull-down while SCL is high unless the model allows it (R1)
  always @(negedge clk)
    if (rstN && sclM && !mayDrive && sdaDriveLow)
      chk(1'b0, "R1 unexpected SDA drive", 1, 0);

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bitCycle(input bit v, input bit drv, output bit s);
    sdaM = v; waitQ();
    mayDrive = drv; sclM = 1'b1; waitQ();
    s = sdaBus; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic startCond();
    mayDrive = 1'b0;
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic stopCond();
    mayDrive = 1'b0;
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ(); waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, input bit expAck, input string req);
    bit s;
    for (int i = 7; i >= 0; i--) bitCycle(b[i], 1'b0, s);
    bitCycle(1'b1, expAck, s);
    chk((s == 1'b0) == expAck, req, s, !expAck);
  endtask

  task automatic readByte(input logic [7:0] exp, input bit masterAck, input string req);
    bit s;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin bitCycle(1'b1, 1'b1, s); got[i] = s; end
    chk(got == exp, req, got, exp);
    bitCycle(!masterAck, 1'b0, s);
  endtask

  task automatic expWrite(input logic [2:0] st, input logic [7:0] d, input logic [1:0] idx);
    expQ.push_back({st, d, idx});
  endtask

  task automatic cmpQueues(input string req);
    repeat (4) @(negedge clk);
    chk(gotQ.size() == expQ.size(), req, gotQ.size(), expQ.size());
    for (int i = 0; i < expQ.size() && i < gotQ.size(); i++)
      chk(gotQ[i] == expQ[i], req, gotQ[i], expQ[i]);
    gotQ.delete(); expQ.delete();
  endtask

  task automatic checkIdle(input string req);
    chk(tgtSel == 3'b000 && !isRead && !sdaDriveLow, req, {tgtSel, isRead, sdaDriveLow}, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R11: reset state
    chk({sdaDriveLow, tgtSel, isRead, wrStrobe, wrData, dataIdx, rdStrobe} == '0,
        "R11 reset outputs", {sdaDriveLow, tgtSel, isRead, wrStrobe}, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R2 R3 R4: memory write, two bytes, latch set
    startCond();
    sendByte(8'hA8, 1'b1, "R1 addr ack mem write");
    chk(tgtSel == 3'b001, "R2 mem select", tgtSel, 3'b001);
    chk(isRead == 1'b0, "R3 write direction", isRead, 0);
    sendByte(8'h5A, 1'b1, "R4 data0 ack"); expWrite(3'b001, 8'h5A, 2'd0);
    sendByte(8'h3C, 1'b1, "R4 data1 ack"); expWrite(3'b001, 8'h3C, 2'd1);
    stopCond();
    checkIdle("R9 idle after stop");
    cmpQueues("R4 mem strobes");

    // R1: wrong device type, stays silent for later bytes too
    startCond();
    sendByte(8'hB8, 1'b0, "R1 wrong type nack");
    sendByte(8'h55, 1'b0, "R1 silent after miss");
    chk(tgtSel == 3'b000, "R1 no select on miss", tgtSel, 0);
    stopCond();

    // R1: strap mismatch
    startCond();
    sendByte(8'hA0, 1'b0, "R1 strap mismatch nack");
    stopCond();

    // R2: reserved target code 01
    startCond();
    sendByte(8'hAA, 1'b0, "R2 reserved code nack");
    chk(tgtSel == 3'b000, "R2 reserved no select", tgtSel, 0);
    stopCond();
    cmpQueues("R1 R2 no strobes on miss");

    // R5: latch clear; status writes pass, pot writes are dropped
    weLatch = 1'b0;
    startCond();
    sendByte(8'hAC, 1'b1, "R5 status addr ack");
    chk(tgtSel == 3'b010, "R2 status select", tgtSel, 3'b010);
    sendByte(8'h81, 1'b1, "R5 status data ack"); expWrite(3'b010, 8'h81, 2'd0);
    stopCond();
    startCond();
    sendByte(8'hAE, 1'b1, "R5 pot addr ack");
    chk(tgtSel == 3'b100, "R2 pot select", tgtSel, 3'b100);
    sendByte(8'h42, 1'b1, "R5 blocked write still acked");
    stopCond();
    startCond();
    sendByte(8'hA8, 1'b1, "R5 mem addr ack");
    sendByte(8'h24, 1'b1, "R5 blocked mem write acked");
    stopCond();
    cmpQueues("R5 only status strobe");
    weLatch = 1'b1;

    // R6: third data byte refused
    startCond();
    sendByte(8'hAE, 1'b1, "R6 pot addr ack");
    sendByte(8'h01, 1'b1, "R6 byte0"); expWrite(3'b100, 8'h01, 2'd0);
    sendByte(8'h02, 1'b1, "R6 byte1"); expWrite(3'b100, 8'h02, 2'd1);
    sendByte(8'h03, 1'b0, "R6 byte2 nack");
    stopCond();
    cmpQueues("R6 two strobes only");

    // R7 R8: pot read, master acks first byte, nacks second
    rdData = 8'hC5;
    rdCount = 0;
    startCond();
    sendByte(8'hAF, 1'b1, "R7 read addr ack");
    chk(isRead == 1'b1, "R3 read direction", isRead, 1);
    chk(tgtSel == 3'b100, "R2 pot read select", tgtSel, 3'b100);
    readByte(8'hC5, 1'b1, "R7 first read byte");
    readByte(8'hD6, 1'b0, "R8 second byte after ack");
    chk(sdaDriveLow == 1'b0, "R8 released after nack", sdaDriveLow, 0);
    stopCond();
    checkIdle("R9 idle after read");
    chk(rdCount == 2, "R7 fetch count", rdCount, 2);

    // R10: write then repeated START into a status read
    startCond();
    sendByte(8'hA8, 1'b1, "R10 first addr ack");
    sendByte(8'h11, 1'b1, "R10 data ack"); expWrite(3'b001, 8'h11, 2'd0);
    startCond();
    chk(tgtSel == 3'b000, "R10 select cleared by restart", tgtSel, 0);
    sendByte(8'hAD, 1'b1, "R10 restart addr ack");
    chk(tgtSel == 3'b010 && isRead, "R10 status read selected", {tgtSel, isRead}, 5);
    readByte(8'hE7, 1'b0, "R10 read after restart");
    stopCond();
    cmpQueues("R10 strobes");
    chk(rdCount == 3, "R7 fetch count after restart", rdCount, 3);

    // R1: strap low changes which address matches
    strapA0 = 1'b0;
    repeat (4) @(negedge clk);
    startCond();
    sendByte(8'hA8, 1'b0, "R1 strap low rejects bit3=1");
    stopCond();
    startCond();
    sendByte(8'hA0, 1'b1, "R1 strap low accepts bit3=0");
    sendByte(8'h99, 1'b1, "R4 write with strap low"); expWrite(3'b001, 8'h99, 2'd0);
    stopCond();
    cmpQueues("R4 strap low strobe");

    finishRun();
  end
endmodule